// File: doc/BRIEF.md
# Burst Write Traffic Master with Grant Statistics

This block is a bus master that produces a fixed burst of write traffic toward a shared slave and measures how an arbiter divided that slave's bandwidth. When a start pulse arrives while the block is idle, it stays quiet for a short settling period. It then raises its request and writes one 32-bit word on each cycle that the arbiter grants it. The words go to consecutive word addresses, starting from a base address supplied on a port.

While the burst runs, the block counts the grant periods it received. A grant period begins on each rising edge of the grant. After the final word is written, the block keeps its request up and counts the granted cycles it could not use, until the arbiter withdraws the grant. At that point an interrupt rises. The interrupt and both counts stay frozen until a clear pulse arrives, and the clear also returns the counters to zero. With a weighted round-robin arbiter that gives W cycles per turn, a burst of N words takes ceil(N/W) grant periods and leaves ceil(N/W)*W - N cycles unused.

Top module: `burst_wr_master`

## Requirements
- R1: After reset, req, wr_en and irq are 0, and access_cnt and residual_cnt are 0.
- R2: A start pulse accepted in idle keeps req low for exactly HOLD_CYC (default 10) clock edges after the edge that captures start; req is high after the HOLD_CYC-th edge.
- R3: Word k of a run (k = 0 .. NUM_WORDS-1, default 1024) is written at address base_addr + 4*k with wdata equal to k zero-extended; base_addr is captured when start is accepted.
- R4: wr_en is high only in cycles where both req and gnt are high, and exactly NUM_WORDS writes occur per run.
- R5: access_cnt equals the number of rising edges of gnt seen while words remain to be written, which is ceil(NUM_WORDS/W) when each grant period lasts W cycles.
- R6: residual_cnt equals the number of granted cycles after the last word until gnt falls, which is ceil(NUM_WORDS/W)*W - NUM_WORDS for W-cycle grant periods.
- R7: irq rises the cycle after gnt is seen low following the last word, drops req at the same time, and stays high with both counters unchanged until irq_clr is pulsed.
- R8: An irq_clr pulse while irq is high drops irq and zeroes access_cnt and residual_cnt on the next edge.
- R9: A start pulse during a run is ignored: the address sequence does not restart and the counts are those of an undisturbed run.
- R10: A start pulse while irq is high is ignored: req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| irq_clr | input | 1 | Clears the interrupt and the counters |
| base_addr | input | ADDR_W | First byte address of the burst |
| gnt | input | 1 | Grant from the arbiter |
| req | output | 1 | Request to the arbiter |
| wr_en | output | 1 | A word is written this cycle |
| addr | output | ADDR_W | Write address |
| wdata | output | DATA_W | Write data (word index) |
| irq | output | 1 | Run complete, held until cleared |
| access_cnt | output | CNT_W | Grant periods used by the run |
| residual_cnt | output | RES_W | Unused granted cycles in the last period |

## Verification
A wrong word counter shows up right away as a write to an address outside the expected sequence. It also shows up at the end of the run, as a write count other than NUM_WORDS or an interrupt that comes too early or too late. A grant-edge detector that misses an edge or sees one twice shifts access_cnt by one. That error is visible only when the interrupt rises, so each run's counts are compared against ceil(N/W) and the residual formula for several grant lengths, including the exact-multiple case with a residual of zero. A control sequencer that leaves its terminal state, or accepts a start at the wrong time, shows up within a cycle as req rising while irq is held.

// File: rtl/bwm_pkg.sv
// Package: shared types for the burst write traffic master.
// Assumes: nothing beyond IEEE 1800-2017.
package bwm_pkg;

    // Control phases of one run.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETTLE = 3'd1,
        PH_WRITE = 3'd2,
        PH_TAIL  = 3'd3,
        PH_DONE  = 3'd4
    } bwm_phase_e;

endpackage

// File: rtl/bwm_sequencer.sv
// Module: bwm_sequencer
// Steps a run through idle, settle, write, tail and done. A start pulse is
// taken only in idle. The settle phase lasts SETTLE_CYC edges. The write phase
// ends on the last word. The tail phase ends when the grant drops. Done holds
// until a clear pulse.
// Assumes: SETTLE_CYC >= 1; last_word is valid in the cycle of the final write.
module bwm_sequencer
    import bwm_pkg::*;
#(
    parameter int SETTLE_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       irq_clr,
    input  logic       gnt,
    input  logic       last_word,
    output bwm_phase_e phase,
    output logic       accept,
    output logic       clear_done
);
    localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    bwm_phase_e    phase_q;
    logic [SW-1:0] settle_q;

    // Strobes for accepting a start and for clearing a finished run.
    always_comb begin
        accept     = (phase_q == PH_IDLE) && start;
        clear_done = (phase_q == PH_DONE) && irq_clr;
    end

    // Phase register and transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   if (start) phase_q <= PH_SETTLE;
                PH_SETTLE: if (settle_q == SETTLE_LAST) phase_q <= PH_WRITE;
                PH_WRITE:  if (gnt && last_word) phase_q <= PH_TAIL;
                PH_TAIL:   if (!gnt) phase_q <= PH_DONE;
                PH_DONE:   if (irq_clr) phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Settle counter: counts edges spent in the settle phase.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_q != PH_SETTLE) begin
            settle_q <= '0;
        end else begin
            settle_q <= settle_q + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/bwm_addr_gen.sv
// Module: bwm_addr_gen
// Holds the word index and the write address of the run. Both are loaded at
// start acceptance and advance by one word on every write.
// Assumes: base_addr is word aligned (its low two bits are dropped).
module bwm_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              last_word
);
    localparam int IW = $clog2(NUM_WORDS + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(NUM_WORDS - 1);

    logic [IW-1:0]     idx_q;
    logic [ADDR_W-1:0] addr_q;

    // Word index and address: load on accept, step on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
        end else if (load) begin
            idx_q  <= '0;
            addr_q <= {base_addr[ADDR_W-1:2], 2'b00};
        end else if (advance) begin
            idx_q  <= idx_q + 1'b1;
            addr_q <= addr_q + ADDR_W'(4);
        end
    end

    // Outputs: data is the word index, widened to the bus.
    always_comb begin
        addr      = addr_q;
        wdata     = DATA_W'(idx_q);
        last_word = (idx_q == IDX_LAST);
    end
endmodule

// File: rtl/bwm_stats.sv
// Module: bwm_stats
// Counts the grant periods that start while words remain, and the granted
// cycles left unused after the last word. Both counters clear on a clear
// strobe and otherwise hold.
// Assumes: the grant input is synchronous to clk.
module bwm_stats #(
    parameter int CNT_W = 11,
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             gnt,
    input  logic             writing,
    input  logic             tail,
    output logic [CNT_W-1:0] access_cnt,
    output logic [RES_W-1:0] residual_cnt
);
    logic             gnt_q;
    logic [CNT_W-1:0] acc_q;
    logic [RES_W-1:0] res_q;

    // Delayed grant for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= 1'b0;
        else        gnt_q <= gnt;
    end

    // Grant-period counter: one count per rising grant in the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 acc_q <= '0;
        else if (writing && gnt && !gnt_q) acc_q <= acc_q + 1'b1;
    end

    // Residual counter: granted cycles in the tail phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     res_q <= '0;
        else if (tail && gnt)  res_q <= res_q + 1'b1;
    end

    assign access_cnt   = acc_q;
    assign residual_cnt = res_q;
endmodule

// File: rtl/burst_wr_master.sv
// Module: burst_wr_master (top)
// Bus-master traffic source. It writes NUM_WORDS words through a request/grant
// handshake and records the grant periods used and the residual granted
// cycles. The interrupt is raised on completion and held until cleared.
// Assumes: the arbiter keeps gnt low while req is low.
module burst_wr_master
    import bwm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int NUM_WORDS  = 1024,
    parameter int SETTLE_CYC = 10,
    parameter int CNT_W      = $clog2(NUM_WORDS + 1),
    parameter int RES_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              irq_clr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              gnt,
    output logic              req,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              irq,
    output logic [CNT_W-1:0]  access_cnt,
    output logic [RES_W-1:0]  residual_cnt
);
    bwm_phase_e phase;
    logic       accept;
    logic       clear_done;
    logic       last_word;
    logic       writing;
    logic       tail;

    bwm_sequencer #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .irq_clr    (irq_clr),
        .gnt        (gnt),
        .last_word  (last_word),
        .phase      (phase),
        .accept     (accept),
        .clear_done (clear_done)
    );

    // Phase decode for the handshake and the counters.
    always_comb begin
        writing = (phase == PH_WRITE);
        tail    = (phase == PH_TAIL);
        req     = writing || tail;
        wr_en   = writing && gnt;
        irq     = (phase == PH_DONE);
    end

    bwm_addr_gen #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .base_addr (base_addr),
        .advance   (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .last_word (last_word)
    );

    bwm_stats #(.CNT_W(CNT_W), .RES_W(RES_W)) u_stats (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (accept || clear_done),
        .gnt          (gnt),
        .writing      (writing),
        .tail         (tail),
        .access_cnt   (access_cnt),
        .residual_cnt (residual_cnt)
    );
endmodule

// File: rtl/bwm_checker.sv
// Module: bwm_checker
// Temporal checks on the ports of burst_wr_master, attached by bind.
// Assumes: the same parameter values as the bound instance.
module bwm_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 11,
    parameter int RES_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              irq_clr,
    input logic              gnt,
    input logic              req,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic [CNT_W-1:0]  access_cnt,
    input logic [RES_W-1:0]  residual_cnt
);
    // R4
    wr_only_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (req && gnt));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr == $past(addr) + ADDR_W'(4)));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> (irq && $stable(access_cnt) && $stable(residual_cnt)));

    // R10
    no_req_in_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !req);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> (!irq && access_cnt == '0 && residual_cnt == '0));
endmodule

bind burst_wr_master bwm_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .RES_W  (RES_W)
) u_bwm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .irq_clr      (irq_clr),
    .gnt          (gnt),
    .req          (req),
    .wr_en        (wr_en),
    .addr         (addr),
    .irq          (irq),
    .access_cnt   (access_cnt),
    .residual_cnt (residual_cnt)
);

// File: tb/tb_burst_wr_master.sv
module tb_burst_wr_master;
    localparam int N   = 1024;
    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        irq_clr = 1'b0;
    logic [31:0] base_addr = 32'h2000_8000;
    logic        gnt = 1'b0;
    logic        req, wr_en, irq;
    logic [31:0] addr, wdata;
    logic [10:0] access_cnt;
    logic [15:0] residual_cnt;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct { int acc; int res; } exp_t;
    exp_t exp_q[$];

    int arb_w = 8;
    int gcnt = 0;
    int gap = 0;
    logic [31:0] cur_base = 32'h2000_8000;
    int words = 0;
    int bad_writes = 0;
    int runs_seen = 0;

    always #10 clk = ~clk;

    burst_wr_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .irq_clr(irq_clr),
        .base_addr(base_addr), .gnt(gnt), .req(req), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .irq(irq),
        .access_cnt(access_cnt), .residual_cnt(residual_cnt)
    );

    // Weighted arbiter model: grants arb_w cycles, then a gap for a competitor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt <= 1'b0; gcnt <= 0; gap <= 0;
        end else if (gnt) begin
            if (gcnt == arb_w - 1) begin gnt <= 1'b0; gap <= GAP; end
            else gcnt <= gcnt + 1;
        end else if (gap > 0) begin
            gap <= gap - 1;
        end else if (req) begin
            gnt <= 1'b1; gcnt <= 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: checks every write, and pops the expected statistics when irq rises.
    initial begin
        logic irq_prev;
        exp_t e;
        irq_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && wr_en) begin
                if (!gnt || addr != cur_base + 32'(4 * words) || wdata != 32'(words))
                    bad_writes++;
                words++;
            end
            if (irq && !irq_prev) begin
                runs_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected irq", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(words == N, "R4 write count", words, N);
                    check(bad_writes == 0, "R3 address/data sequence", bad_writes, 0);
                    check(int'(access_cnt) == e.acc, "R5 access_cnt", int'(access_cnt), e.acc);
                    check(int'(residual_cnt) == e.res, "R6 residual_cnt", int'(residual_cnt), e.res);
                end
                words = 0;
                bad_writes = 0;
            end
            irq_prev = irq;
        end
    end

    // Driver: queues the expected result, starts a run and finishes it with a clear.
    task automatic run(input int w, input logic [31:0] base, input bit poke_start);
        exp_t e;
        e.acc = (N + w - 1) / w;
        e.res = e.acc * w - N;
        exp_q.push_back(e);
        arb_w = w;
        @(negedge clk);
        base_addr = base;
        cur_base = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = 32'hDEAD_0000;
        if (poke_start) begin
            repeat (100) @(negedge clk);
            // R9: start during the run must not restart it
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!irq) @(negedge clk);
        // R7: irq and counts hold with no clear
        repeat (5) @(negedge clk);
        check(irq == 1'b1 && req == 1'b0, "R7 irq held", int'(irq), 1);
        check(int'(access_cnt) == e.acc, "R7 access_cnt held", int'(access_cnt), e.acc);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq == 1'b0, "R8 irq cleared", int'(irq), 0);
        check(access_cnt == 0 && residual_cnt == 0, "R8 counters zeroed",
              int'(access_cnt) + int'(residual_cnt), 0);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req == 0 && wr_en == 0 && irq == 0, "R1 outputs low in reset", int'(req) + int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(access_cnt == 0 && residual_cnt == 0, "R1 counters zero", int'(access_cnt), 0);
        check(req == 0 && irq == 0, "R1 idle after reset", int'(req), 0);

        // R2: settle period of 10 edges before req
        arb_w = 8;
        exp_q.push_back('{acc: 128, res: 0});
        base_addr = 32'h2000_8000;
        cur_base = 32'h2000_8000;
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        repeat (9) @(posedge clk);
        #1 check(req == 1'b0, "R2 req low during settle", int'(req), 0);
        @(posedge clk);
        #1 check(req == 1'b1, "R2 req high after settle", int'(req), 1);
        while (!irq) @(negedge clk);
        @(negedge clk);
        // R10: start while irq pending is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        check(req == 1'b0 && irq == 1'b1, "R10 start ignored while irq", int'(req), 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(access_cnt == 0, "R8 clear after first run", int'(access_cnt), 0);

        run(30, 32'h2000_C000, 1'b0);
        run(10, 32'h2000_8000, 1'b1);   // R9 exercised here
        run(1, 32'h2000_0100, 1'b0);
        run(1000, 32'h2000_C000, 1'b0);
        run(7, 32'h2000_8000, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && runs_seen == 6, "R5 all runs completed", runs_seen, 6);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule